// File: doc/BRIEF.md
# PUF Excitation and Capture Controller

This block drives the shared excite line of an array of 128 cross-coupled latch cells and captures the value the array settles to. Between measurements the excite line rests low, which holds every cell in its precharged state with all outputs high. A measurement command raises the line for a programmed number of system clock cycles. During that window the latches resolve from device mismatch. On the last high cycle the controller registers the whole 128-bit word. The line then drops, and a one-cycle done pulse marks the new result.

The pulse length works as a reliability knob that can be changed at run time. A longer pulse gives more cells time to resolve firmly, at the cost of measurement latency. The default after reset is the longest pulse, 256 cycles, which is about 5.12 µs at 50 MHz. The host can write a new length at any time, and that length applies to the next measurement that starts.

Top module: `puf_excite_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `excite`, `busy` and `done` are low and `resp` is all zeros.
- R2: A `meas_start` sampled high while idle drives `excite` high from the next cycle for exactly D consecutive cycles, where D is the pulse length read on `dur_rdata` in the cycle the start was sampled.
- R3: After reset the pulse length reads back as 256.
- R4: A write on `dur_wr` stores the value clamped into 1..256: a written 0 reads back and acts as 1, and any value above 256 reads back and acts as 256. `dur_rdata` never leaves that range.
- R5: `resp` is loaded with `cell_in` as sampled in the last high cycle of the pulse. It holds that value unchanged until the next capture.
- R6: `done` is high for exactly one cycle. That cycle is the first cycle in which `excite` is low again after a pulse.
- R7: `busy` is high whenever `excite` is high and stays high through the `done` cycle. A `meas_start` sampled while `busy` is high is ignored and produces no further pulse.
- R8: Between two pulses `excite` stays low for at least one cycle. With `meas_start` held high, the gap is exactly two cycles.
- R9: A pulse-length write made during a running pulse does not change that pulse. It takes effect for the next measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dur_wr | input | 1 | Write strobe for the pulse-length register |
| dur_wdata | input | 9 | Requested pulse length in cycles |
| dur_rdata | output | 9 | Current, clamped pulse length |
| meas_start | input | 1 | Measurement command, sampled while idle |
| cell_in | input | 128 | Outputs of the latch cell array |
| excite | output | 1 | Shared excite line to the cell array; low holds the precharge |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when `resp` has been updated |
| resp | output | 128 | Captured response word |

## Verification
Two situations are hard to reach from the ports. The first is a start command that lands in the single rest cycle, where `done` is high and `excite` has just dropped; it would be easy to misread that cycle as idle. The bench raises `meas_start` in exactly the cycle it sees `done`, and then checks that no new pulse follows. The second is proving that the capture happens on the last high cycle and not earlier. For this, the behavioural cell model returns fresh random values until a fixed settling count of high cycles and a known pattern after it. The bench uses pulse lengths that place the last cycle exactly on that settling boundary. Any capture one cycle early would then return noise instead of the pattern.

// File: rtl/puf_exc_pkg.sv
// Shared types for the PUF excitation controller.
// Assumes: a single clock domain; reset is synchronous and active low.
package puf_exc_pkg;

    // Sequencer phases: precharge/idle, excite high, one-cycle rest after the pulse
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXCITE = 2'd1,
        ST_REST   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/puf_dur_reg.sv
// Pulse-length register. It stores the excite duration in clock cycles and
// clamps each write into 1..DUR_MAX.
// Assumes: DUR_W is wide enough to hold DUR_MAX, and DUR_RST lies in 1..DUR_MAX.
module puf_dur_reg #(
    parameter int DUR_W   = 9,
    parameter int DUR_MAX = 256,
    parameter int DUR_RST = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DUR_W-1:0] wr_val,
    output logic [DUR_W-1:0] dur
);
    localparam logic [DUR_W-1:0] MAX_V = DUR_W'(DUR_MAX);
    localparam logic [DUR_W-1:0] RST_V = DUR_W'(DUR_RST);
    localparam logic [DUR_W-1:0] MIN_V = DUR_W'(1);

    logic [DUR_W-1:0] clamped;

    // Map a requested value into the legal range
    always_comb begin
        if (wr_val == '0)
            clamped = MIN_V;
        else if (wr_val > MAX_V)
            clamped = MAX_V;
        else
            clamped = wr_val;
    end

    // Hold the programmed length; reset loads the robust default
    always_ff @(posedge clk) begin
        if (!rst_n)
            dur <= RST_V;
        else if (wr_en)
            dur <= clamped;
    end
endmodule

// File: rtl/puf_seq_fsm.sv
// Excitation sequencer. A start sampled while idle raises excite for dur cycles.
// It asserts capture on the last high cycle, then rests low for one cycle with
// done high before it accepts another start.
// Assumes: dur is always in 1..2**DUR_W-1; the duration register guarantees this.
module puf_seq_fsm
    import puf_exc_pkg::*;
#(
    parameter int DUR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DUR_W-1:0] dur,
    output logic             excite,
    output logic             busy,
    output logic             capture,
    output logic             done
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    seq_state_t       state;
    logic [DUR_W-1:0] remain;

    // Last high cycle: the counter has run out while exciting
    always_comb capture = (state == ST_EXCITE) && (remain == '0);

    // Outputs decoded from the registered phase
    always_comb begin
        excite = (state == ST_EXCITE);
        busy   = (state != ST_IDLE);
    end

    // Phase register, cycle counter and the registered done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_EXCITE;
                        remain <= dur - ONE;
                    end
                end
                ST_EXCITE: begin
                    if (remain == '0)
                        state <= ST_REST;
                    else
                        remain <= remain - ONE;
                end
                ST_REST: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/puf_resp_cap.sv
// Response capture register, split into slices that match the cell groups of
// the array. Every slice loads on the same capture strobe.
// Assumes: N_CELLS is a multiple of GROUP.
module puf_resp_cap #(
    parameter int N_CELLS = 128,
    parameter int GROUP   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [N_CELLS-1:0] cell_in,
    output logic [N_CELLS-1:0] resp
);
    localparam int N_GROUPS = N_CELLS / GROUP;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_slice
        // One slice register per cell group, loaded on the capture strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                resp[g*GROUP +: GROUP] <= '0;
            else if (capture)
                resp[g*GROUP +: GROUP] <= cell_in[g*GROUP +: GROUP];
        end
    end
endmodule

// File: rtl/puf_excite_ctrl.sv
// Top level of the PUF excitation and capture controller. It connects the
// pulse-length register, the sequencer and the response register.
// Assumes: cell_in follows the array outputs directly (all ones while excite is low).
module puf_excite_ctrl #(
    parameter int N_CELLS = 128,
    parameter int GROUP   = 4,
    parameter int DUR_W   = 9,
    parameter int DUR_MAX = 256,
    parameter int DUR_RST = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dur_wr,
    input  logic [DUR_W-1:0]   dur_wdata,
    output logic [DUR_W-1:0]   dur_rdata,
    input  logic               meas_start,
    input  logic [N_CELLS-1:0] cell_in,
    output logic               excite,
    output logic               busy,
    output logic               done,
    output logic [N_CELLS-1:0] resp
);
    logic capture;

    puf_dur_reg #(
        .DUR_W  (DUR_W),
        .DUR_MAX(DUR_MAX),
        .DUR_RST(DUR_RST)
    ) u_dur (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dur_wr),
        .wr_val(dur_wdata),
        .dur   (dur_rdata)
    );

    puf_seq_fsm #(
        .DUR_W(DUR_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (meas_start),
        .dur    (dur_rdata),
        .excite (excite),
        .busy   (busy),
        .capture(capture),
        .done   (done)
    );

    puf_resp_cap #(
        .N_CELLS(N_CELLS),
        .GROUP  (GROUP)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .cell_in(cell_in),
        .resp   (resp)
    );
endmodule

// File: rtl/puf_excite_ctrl_chk.sv
// Assertion checker for puf_excite_ctrl, attached with bind. It measures each
// excite pulse with its own counter and compares the result against the length
// that was programmed when the pulse started.
module puf_excite_ctrl_chk #(
    parameter int N_CELLS = 128,
    parameter int DUR_W   = 9,
    parameter int DUR_MAX = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DUR_W-1:0]   dur_rdata,
    input logic               excite,
    input logic               busy,
    input logic               done,
    input logic [N_CELLS-1:0] resp
);
    logic             prev_exc;
    logic [DUR_W-1:0] prev_dur;
    logic [DUR_W-1:0] snap;
    logic [DUR_W-1:0] run;

    // Track the length of the current pulse and the length in force when it began
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_exc <= 1'b0;
            prev_dur <= '0;
            snap     <= '0;
            run      <= '0;
        end else begin
            prev_exc <= excite;
            prev_dur <= dur_rdata;
            if (excite && !prev_exc) begin
                snap <= prev_dur;
                run  <= DUR_W'(1);
            end else if (excite) begin
                run <= run + DUR_W'(1);
            end
        end
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_exc && !excite) |-> (run == snap)); // R2

    AST_DUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dur_rdata >= DUR_W'(1)) && (dur_rdata <= DUR_W'(DUR_MAX))); // R4

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(resp)); // R5

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(excite) |-> done); // R6

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (excite || done) |-> busy); // R7

    AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(excite) |=> !excite); // R8
endmodule

bind puf_excite_ctrl puf_excite_ctrl_chk #(
    .N_CELLS(N_CELLS),
    .DUR_W  (DUR_W),
    .DUR_MAX(DUR_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dur_rdata(dur_rdata),
    .excite   (excite),
    .busy     (busy),
    .done     (done),
    .resp     (resp)
);

// File: tb/puf_excite_ctrl_test.sv
// Scoreboard bench for puf_excite_ctrl. A behavioural cell array returns noise
// until SETTLE high cycles have passed and a fixed pattern after that.
module puf_excite_ctrl_test;
    localparam int N      = 128;
    localparam int DW     = 9;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dur_wr = 1'b0;
    logic [DW-1:0] dur_wdata = '0;
    logic          meas_start = 1'b0;
    logic [N-1:0]  cell_in;
    logic [DW-1:0] dur_rdata;
    logic          excite, busy, done;
    logic [N-1:0]  resp;

    puf_excite_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dur_wr(dur_wr), .dur_wdata(dur_wdata),
        .dur_rdata(dur_rdata), .meas_start(meas_start), .cell_in(cell_in),
        .excite(excite), .busy(busy), .done(done), .resp(resp)
    );

    always #10 clk = ~clk;

    // Behavioural cell array
    int           ecnt = 0;
    logic [N-1:0] noise = '0;
    logic [N-1:0] pattern = '0;
    always @(posedge clk) begin
        if (!excite) ecnt <= 0;
        else         ecnt <= ecnt + 1;
        noise <= {$urandom, $urandom, $urandom, $urandom};
    end
    always_comb cell_in = !excite ? '1 : ((ecnt >= SETTLE) ? pattern : noise);

    // Scoreboard
    int           checks = 0;
    int           fails = 0;
    int           hi_cnt = 0;
    int           done_cnt = 0;
    int           q_len[$];
    bit           q_set[$];
    logic [N-1:0] q_pat[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: measure pulses and compare each result against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (excite) hi_cnt++;
            if (done) begin
                done_cnt++;
                if (q_len.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    int           el;
                    bit           es;
                    logic [N-1:0] ep;
                    el = q_len.pop_front();
                    es = q_set.pop_front();
                    ep = q_pat.pop_front();
                    chk(hi_cnt == el, "R2", "excite pulse length", hi_cnt, el);
                    if (es) chk(resp == ep, "R5", "captured response", resp, ep);
                end
                hi_cnt = 0;
            end
        end
    end

    task automatic expect_item(input int len, input logic [N-1:0] pat);
        q_len.push_back(len);
        q_set.push_back((len - 1) >= SETTLE);
        q_pat.push_back(pat);
    endtask

    task automatic wr(input int v);
        @(negedge clk);
        dur_wr = 1'b1;
        dur_wdata = DW'(v);
        @(negedge clk);
        dur_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Driver: one complete measurement with its expected result
    task automatic measure(input int len, input logic [N-1:0] pat);
        pattern = pat;
        expect_item(len, pat);
        pulse_start();
        chk(busy && excite, "R7", "busy and excite after start", {busy, excite}, 2'b11);
        wait_done();
        chk(!excite, "R6", "excite low in done cycle", excite, 0);
        @(negedge clk);
        chk(!done, "R6", "done lasts one cycle", done, 0);
        chk(!busy && !excite, "R8", "idle after rest", {busy, excite}, 0);
    endtask

    localparam logic [N-1:0] P1 = {4{32'hA5C3_1E97}};
    localparam logic [N-1:0] P2 = {32'h0F0F_00FF, 32'h1234_5678, 32'hDEAD_BEEF, 32'h8000_0001};
    localparam logic [N-1:0] P3 = ~P1;

    initial begin
        repeat (3) @(negedge clk);
        chk(!excite && !busy && !done, "R1", "outputs during reset", {excite, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!excite && !busy && !done, "R1", "outputs after reset", {excite, busy, done}, 0);
        chk(resp == '0, "R1", "response after reset", resp, 0);
        chk(dur_rdata == 9'd256, "R3", "default length", dur_rdata, 256);

        measure(256, P1); // R3 default pulse

        wr(0);
        chk(dur_rdata == 9'd1, "R4", "zero clamps to one", dur_rdata, 1);
        measure(1, P2);
        wr(300);
        chk(dur_rdata == 9'd256, "R4", "300 clamps to 256", dur_rdata, 256);
        wr(257);
        chk(dur_rdata == 9'd256, "R4", "257 clamps to 256", dur_rdata, 256);
        wr(256);
        chk(dur_rdata == 9'd256, "R4", "256 kept", dur_rdata, 256);

        wr(40);
        measure(40, P2);
        wr(17);
        measure(17, P3);   // R5 last cycle lands exactly on the settling edge
        wr(5);
        measure(5, P1);

        // R7: starts during the pulse and during the rest cycle are ignored
        wr(30);
        pattern = P2;
        expect_item(30, P2);
        pulse_start();
        repeat (10) @(negedge clk);
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        wait_done();
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        begin
            int n0;
            bit seen;
            n0 = done_cnt;
            seen = 1'b0;
            for (int i = 0; i < 40; i++) begin
                if (excite) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R7", "no pulse from ignored starts", seen, 0);
            chk(done_cnt == n0, "R7", "no extra done", done_cnt, n0);
        end
        chk(resp == P2, "R5", "response held after ignored starts", resp, P2);

        // R9: a write during the pulse applies only to the next run
        pattern = P3;
        expect_item(30, P3);
        pulse_start();
        repeat (5) @(negedge clk);
        dur_wr = 1'b1;
        dur_wdata = 9'd60;
        @(negedge clk);
        dur_wr = 1'b0;
        chk(dur_rdata == 9'd60, "R9", "new length read back", dur_rdata, 60);
        wait_done();
        @(negedge clk);
        measure(60, P1);

        // R8: start held high gives back-to-back pulses with a two-cycle gap
        wr(20);
        pattern = P2;
        expect_item(20, P2);
        expect_item(20, P2);
        @(negedge clk);
        meas_start = 1'b1;
        @(negedge clk);
        wait_done();
        begin
            int lo;
            lo = 0;
            while (!excite && lo < 10) begin
                lo++;
                @(negedge clk);
            end
            chk(lo == 2, "R8", "low gap with start held", lo, 2);
        end
        @(negedge clk);
        wait_done();
        meas_start = 1'b0;
        repeat (30) @(negedge clk);
        chk(!excite && !busy, "R8", "stopped after start released", {excite, busy}, 0);
        chk(q_len.size() == 0, "R2", "all expected pulses seen", q_len.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule